// File: doc/BRIEF.md
# Power-On Reset Supervisor

This block decides when the rest of the chip may leave reset. It watches a digital supply-good bit from an analog comparator and an oscillator-stable flag, both asynchronous to its own free-running sample clock. Short dips on the supply-good bit are filtered out. A dip that lasts longer than a programmable time (250 ns by default) puts the chip back into reset. Release waits for two things: the supply must stay high for a programmable hold-off (2 ms by default), and the oscillator must be reported stable.

The block drives two reset outputs. The active-low presence reset output stays low for the whole supply and oscillator qualification. It is intended to gate the bus-presence pull-up, so a host cannot detect the device while that output is low. When it rises, a second programmable delay starts (2 ms by default), and the internal chip reset stays asserted during it. When that delay ends, the chip reset falls and a one-cycle start pulse tells the configuration loader to begin. A qualifying dip at any point sends the whole sequence back to its first step.

Top module: `por_supervisor`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `core_rst_o` is 1, `presence_rst_n_o` is 0 and `cfg_start_o` is 0.
- R2: A low on `supply_ok_i` that is seen at fewer than FILT_CYC consecutive rising clock edges (FILT_CYC = ceil(DIP_NS x CLK_MHZ / 1000) + 1, which is 14 by default) changes no output when the block is in the post-release delay or in normal running.
- R3: A low on `supply_ok_i` seen at FILT_CYC or more consecutive edges is qualifying. Counting the edge that first registers the low as edge 1 after the input changes, `presence_rst_n_o` goes to 0 and `core_rst_o` goes to 1 after edge FILT_CYC+3.
- R4: While the synchronized `supply_ok_i` is low, the reset outputs are never released.
- R5: With the oscillator stable, `presence_rst_n_o` rises after edge HOLD_CYC+4, counted from the first edge after `supply_ok_i` rises following a qualifying low (HOLD_CYC = HOLD_US x CLK_MHZ). Any low sample during this hold-off restarts the count.
- R6: `presence_rst_n_o` does not rise while the synchronized `osc_stable_i` is low, and every low sample restarts the hold-off count. If the supply has been high for some time, `presence_rst_n_o` rises after edge HOLD_CYC+2, counted from the first edge after `osc_stable_i` rises.
- R7: Whenever `presence_rst_n_o` is 0, `core_rst_o` is 1.
- R8: `core_rst_o` falls exactly POST_CYC edges after `presence_rst_n_o` rises (POST_CYC = POST_US x CLK_MHZ), regardless of short dips.
- R9: `cfg_start_o` is high for exactly one cycle. That cycle is the one in which `core_rst_o` first reads 0.
- R10: A qualifying low during the post-release delay drives `presence_rst_n_o` low again, and the full hold-off and delay sequence restarts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running sample clock |
| rst | input | 1 | Synchronous active-high reset of the supervisor state |
| supply_ok_i | input | 1 | Asynchronous supply-good bit from the comparator |
| osc_stable_i | input | 1 | Asynchronous oscillator-stable indication |
| core_rst_o | output | 1 | Chip-wide reset, active high |
| presence_rst_n_o | output | 1 | Active-low reset output, used to gate the bus-presence pull-up |
| cfg_start_o | output | 1 | One-cycle pulse that starts configuration loading |

## Verification
Two situations are hard to reach from the ports: a dip exactly one sample shorter than the filter threshold, and a dip exactly at that threshold. Both must land while the block is in the post-release delay, where a wrong response does not end reset but only moves the start pulse. The stimulus waits a fixed number of cycles after `presence_rst_n_o` rises, then drops `supply_ok_i` for FILT_CYC-1 and for FILT_CYC sample periods. The scoreboard then confirms either that the start pulse keeps its original cycle, or that the sequence restarts with its full length. A short dip during the hold-off is used to show that the count restarts, which makes release later by a known amount.

// File: rtl/por_pkg.sv
package por_pkg;

  typedef enum logic [1:0] {
    ST_RESET = 2'd0,
    ST_HOLD  = 2'd1,
    ST_DELAY = 2'd2,
    ST_RUN   = 2'd3
  } por_state_e;

  // cycles strictly longer than a given number of nanoseconds
  function automatic int unsigned over_ns_cycles(int unsigned ns, int unsigned mhz);
    return (ns * mhz + 999) / 1000 + 1;
  endfunction

endpackage

// File: rtl/por_sync.sv
module por_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [W-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          stage_q[g] <= RST_VAL;
        end else begin
          if (g == 0) begin
            stage_q[g] <= async_i;
          end else begin
            stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
          end
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];

  // R4
  sync_delay_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> sync_o == $past(stage_q[(STAGES > 1) ? STAGES-2 : 0]));

endmodule

// File: rtl/por_dip_filter.sv
module por_dip_filter #(
  parameter int unsigned FILT_CYC = 14,
  localparam int unsigned CW = $clog2(FILT_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  output logic dip_o
);

  logic [CW-1:0] low_cnt_q;
  logic          dip_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt_q <= '0;
      dip_q     <= 1'b0;
    end else if (level_i) begin
      low_cnt_q <= '0;
      dip_q     <= 1'b0;
    end else begin
      if (low_cnt_q != CW'(FILT_CYC)) begin
        low_cnt_q <= low_cnt_q + 1'b1;
      end
      dip_q <= (low_cnt_q >= CW'(FILT_CYC - 1));
    end
  end

  assign dip_o = dip_q;

  // R3
  dip_needs_low_chk: assert property (@(posedge clk) disable iff (rst)
    dip_o |-> !$past(level_i));

  // R2
  dip_clear_chk: assert property (@(posedge clk) disable iff (rst)
    level_i |=> !dip_o);

endmodule

// File: rtl/por_timer.sv
module por_timer #(
  parameter int unsigned CW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          dec_i,
  output logic          zero_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (dec_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);

  // R8
  dec_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load_i) && $past(dec_i) && $past(cnt_q) != '0)
      |-> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/por_supervisor.sv
module por_supervisor #(
  parameter int unsigned CLK_MHZ = 50,
  parameter int unsigned DIP_NS  = 250,
  parameter int unsigned HOLD_US = 2000,
  parameter int unsigned POST_US = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok_i,
  input  logic osc_stable_i,
  output logic core_rst_o,
  output logic presence_rst_n_o,
  output logic cfg_start_o
);
  import por_pkg::*;

  localparam int unsigned FILT_CYC = over_ns_cycles(DIP_NS, CLK_MHZ);
  localparam int unsigned HOLD_CYC = HOLD_US * CLK_MHZ;
  localparam int unsigned POST_CYC = POST_US * CLK_MHZ;
  localparam int unsigned MAX_CYC  = (HOLD_CYC > POST_CYC) ? HOLD_CYC : POST_CYC;
  localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] HOLD_LD = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] POST_LD = CNT_W'(POST_CYC - 1);

  logic [1:0] raw_in, sync_in;
  logic       sup_s, osc_s, dip;

  assign raw_in = {osc_stable_i, supply_ok_i};

  por_sync #(.W(2), .STAGES(2), .RST_VAL(2'b00)) i_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (raw_in),
    .sync_o  (sync_in)
  );

  assign sup_s = sync_in[0];
  assign osc_s = sync_in[1];

  por_dip_filter #(.FILT_CYC(FILT_CYC)) i_filt (
    .clk     (clk),
    .rst     (rst),
    .level_i (sup_s),
    .dip_o   (dip)
  );

  por_state_e       st_q, st_d;
  logic             tm_load, tm_dec, tm_zero;
  logic [CNT_W-1:0] tm_val;

  por_timer #(.CW(CNT_W)) i_timer (
    .clk        (clk),
    .rst        (rst),
    .load_i     (tm_load),
    .load_val_i (tm_val),
    .dec_i      (tm_dec),
    .zero_o     (tm_zero)
  );

  logic good;
  assign good = sup_s && osc_s;

  always_comb begin
    st_d    = st_q;
    tm_load = 1'b0;
    tm_val  = HOLD_LD;
    tm_dec  = 1'b0;
    unique case (st_q)
      ST_RESET: begin
        if (sup_s && !dip) begin
          st_d    = ST_HOLD;
          tm_load = 1'b1;
        end
      end
      ST_HOLD: begin
        if (!good) begin
          tm_load = 1'b1;
        end else if (tm_zero) begin
          st_d    = ST_DELAY;
          tm_load = 1'b1;
          tm_val  = POST_LD;
        end else begin
          tm_dec = 1'b1;
        end
      end
      ST_DELAY: begin
        if (tm_zero) begin
          st_d = ST_RUN;
        end else begin
          tm_dec = 1'b1;
        end
      end
      ST_RUN: begin
        st_d = ST_RUN;
      end
      default: st_d = ST_RESET;
    endcase
    if (dip) begin
      st_d = ST_RESET;
    end
  end

  logic core_rst_q, pres_q, cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_RESET;
      core_rst_q <= 1'b1;
      pres_q     <= 1'b0;
      cfg_q      <= 1'b0;
    end else begin
      st_q       <= st_d;
      core_rst_q <= (st_d != ST_RUN);
      pres_q     <= (st_d == ST_DELAY) || (st_d == ST_RUN);
      cfg_q      <= (st_q == ST_DELAY) && (st_d == ST_RUN);
    end
  end

  assign core_rst_o       = core_rst_q;
  assign presence_rst_n_o = pres_q;
  assign cfg_start_o      = cfg_q;

  // R7
  presence_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !presence_rst_n_o |-> core_rst_o);

  // R9
  cfg_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_start_o |=> !cfg_start_o);

  // R9
  cfg_align_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_start_o |-> (!core_rst_o && $past(core_rst_o)));

  // R6
  release_osc_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(presence_rst_n_o) |-> $past(osc_s));

  // R5
  release_supply_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(presence_rst_n_o) |-> $past(sup_s));

  // R3
  dip_entry_chk: assert property (@(posedge clk) disable iff (rst)
    dip |=> !presence_rst_n_o);

  // R4
  hold_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!sup_s && !presence_rst_n_o) |=> !presence_rst_n_o);

endmodule

// File: tb/test_por_supervisor.sv
module test_por_supervisor;

  localparam int unsigned CLK_MHZ = 50;
  localparam int unsigned HOLD_US = 4;
  localparam int unsigned POST_US = 2;
  localparam int H = HOLD_US * CLK_MHZ;  // 200
  localparam int D = POST_US * CLK_MHZ;  // 100
  localparam int F = 14;                 // ceil(250*50/1000)+1

  // event kinds
  localparam int EV_PRES_UP = 1, EV_PRES_DN = 2, EV_CORE_DN = 3,
                 EV_CORE_UP = 4, EV_CFG_UP = 5, EV_CFG_DN = 6;

  typedef struct {
    int    kind;
    int    cyc;
    string req;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_ok = 1'b0;
  logic osc_ok = 1'b1;
  logic core_rst, pres_n, cfg_start;

  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  exp_t exp_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  por_supervisor #(
    .CLK_MHZ(CLK_MHZ), .DIP_NS(250), .HOLD_US(HOLD_US), .POST_US(POST_US)
  ) i_por_supervisor (
    .clk              (clk),
    .rst              (rst),
    .supply_ok_i      (supply_ok),
    .osc_stable_i     (osc_ok),
    .core_rst_o       (core_rst),
    .presence_rst_n_o (pres_n),
    .cfg_start_o      (cfg_start)
  );

  task automatic push(int kind, int at, string req);
    exp_t e;
    e.kind = kind; e.cyc = at; e.req = req;
    exp_q.push_back(e);
  endtask

  // full release sequence once the hold-off count starts fresh
  task automatic push_release(int pres_at, string req_hold);
    push(EV_PRES_UP, pres_at, req_hold);
    push(EV_CORE_DN, pres_at + D, "R8");
    push(EV_CFG_UP, pres_at + D, "R9");
    push(EV_CFG_DN, pres_at + D + 1, "R9");
  endtask

  task automatic chk_ev(int kind);
    exp_t e;
    n_chk++;
    if (exp_q.size() == 0) begin
      n_fail++;
      $display("FAIL R2 unexpected event: actual kind %0d at cycle %0d, expected none", kind, cyc);
    end else begin
      e = exp_q.pop_front();
      if (e.kind != kind || e.cyc != cyc) begin
        n_fail++;
        $display("FAIL %s event: actual kind %0d cycle %0d, expected kind %0d cycle %0d",
                 e.req, kind, cyc, e.kind, e.cyc);
      end
    end
  endtask

  task automatic check_drained(string req);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL %s missing events: actual %0d pending, expected 0 (next kind %0d at %0d)",
               req, exp_q.size(), exp_q[0].kind, exp_q[0].cyc);
      exp_q.delete();
    end
  endtask

  task automatic check_bit(string req, string name, logic act, logic expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, name, act, expv);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: watch for output changes and compare against the scoreboard
  logic p_pres, p_core, p_cfg;
  always @(negedge clk) begin
    if (rst) begin
      p_pres = pres_n; p_core = core_rst; p_cfg = cfg_start;
    end else begin
      if (!p_pres && pres_n)       chk_ev(EV_PRES_UP);
      if (p_pres && !pres_n)       chk_ev(EV_PRES_DN);
      if (p_core && !core_rst)     chk_ev(EV_CORE_DN);
      if (!p_core && core_rst)     chk_ev(EV_CORE_UP);
      if (!p_cfg && cfg_start)     chk_ev(EV_CFG_UP);
      if (p_cfg && !cfg_start)     chk_ev(EV_CFG_DN);
      p_pres = pres_n; p_core = core_rst; p_cfg = cfg_start;
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout, expected completion");
    finish_run();
  end

  initial begin
    int c0, c1;
    // R1 reset state
    wait_cyc(5);
    check_bit("R1", "core_rst in reset", core_rst, 1'b1);
    check_bit("R1", "presence_rst_n in reset", pres_n, 1'b0);
    check_bit("R1", "cfg_start in reset", cfg_start, 1'b0);
    rst = 1'b0;
    wait_cyc(1);
    check_bit("R1", "core_rst after reset", core_rst, 1'b1);
    check_bit("R1", "presence_rst_n after reset", pres_n, 1'b0);
    check_bit("R1", "cfg_start after reset", cfg_start, 1'b0);

    // R4: supply low keeps everything in reset
    wait_cyc(60);
    check_drained("R4");
    check_bit("R4", "presence_rst_n while supply low", pres_n, 1'b0);

    // R5 first release, then R8/R9
    c0 = cyc;
    supply_ok = 1'b1;
    push_release(c0 + H + 4, "R5");
    wait_cyc(H + D + 20);
    check_drained("R5");

    // R2 short dip in RUN is ignored
    supply_ok = 1'b0;
    wait_cyc(F - 1);
    supply_ok = 1'b1;
    wait_cyc(40);
    check_drained("R2");
    check_bit("R2", "core_rst after short dip", core_rst, 1'b0);

    // R3 qualifying dip of exactly FILT_CYC in RUN
    c0 = cyc;
    supply_ok = 1'b0;
    push(EV_PRES_DN, c0 + F + 3, "R3");
    push(EV_CORE_UP, c0 + F + 3, "R3");
    wait_cyc(F);
    c1 = cyc;
    supply_ok = 1'b1;
    push_release(c1 + H + 4, "R5");
    wait_cyc(H + D + 20);
    check_drained("R3");

    // R6 oscillator not stable blocks release
    c0 = cyc;
    supply_ok = 1'b0;
    osc_ok = 1'b0;
    push(EV_PRES_DN, c0 + F + 3, "R3");
    push(EV_CORE_UP, c0 + F + 3, "R3");
    wait_cyc(30);
    supply_ok = 1'b1;
    wait_cyc(H + 50);
    check_drained("R6");
    check_bit("R6", "presence_rst_n with osc low", pres_n, 1'b0);
    c1 = cyc;
    osc_ok = 1'b1;
    push_release(c1 + H + 2, "R6");
    wait_cyc(H + D + 20);
    check_drained("R6");

    // R5 short dip during hold-off restarts the count;
    // R2 short dip during post-release delay is ignored
    c0 = cyc;
    supply_ok = 1'b0;
    push(EV_PRES_DN, c0 + F + 3, "R3");
    push(EV_CORE_UP, c0 + F + 3, "R3");
    wait_cyc(20);
    supply_ok = 1'b1;
    wait_cyc(50);
    supply_ok = 1'b0;
    wait_cyc(5);
    c1 = cyc;
    supply_ok = 1'b1;
    push_release(c1 + H + 2, "R5");
    wait_cyc(H + 2 + 10);
    supply_ok = 1'b0;
    wait_cyc(F - 1);
    supply_ok = 1'b1;
    wait_cyc(D + 20);
    check_drained("R2");

    // R10 qualifying dip during post-release delay restarts the sequence
    c0 = cyc;
    supply_ok = 1'b0;
    push(EV_PRES_DN, c0 + F + 3, "R3");
    push(EV_CORE_UP, c0 + F + 3, "R3");
    wait_cyc(F + 10);
    c1 = cyc;
    supply_ok = 1'b1;
    push_release(c1 + H + 4, "R10");
    wait_cyc(H + 4 + 20);
    c0 = cyc;
    supply_ok = 1'b0;
    // still in delay: only presence output falls, core reset was never released
    exp_q.delete();
    push(EV_PRES_DN, c0 + F + 3, "R10");
    wait_cyc(F);
    c1 = cyc;
    supply_ok = 1'b1;
    push_release(c1 + H + 4, "R10");
    wait_cyc(H + D + 20);
    check_drained("R10");
    check_bit("R7", "core_rst at end", core_rst, 1'b0);
    check_bit("R7", "presence_rst_n at end", pres_n, 1'b1);

    finish_run();
  end

endmodule